// File: doc/BRIEF.md
# Scoreboard-Managed Computation Unit Front-End

This block sits between a scoreboard and a single-cycle arithmetic unit. An issue strobe captures an opcode. The unit then asks for its two source operands, one request bit per operand. Each operand value is captured from the source bus in the cycle its grant bit is high. When nothing is left to read, a small internal ALU forms the result. The unit raises a write request and holds it until the write side grants it.

A kill input abandons the operation at any stage and returns the unit to idle. A busy output tells the issue logic when the unit can take a new operation.

Top module: `sb_cu_front`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_req_o` is 2'b00, `wr_req_o` is 0 and `busy_o` is 0.
- R2: An issue is accepted only when `busy_o` is low and `kill_i` is low. One cycle later both bits of `rd_req_o` are high, `busy_o` is high, and `op_i` has been captured.
- R3: `rd_req_o` is never non-zero unless an issue has been seen since reset.
- R4: A high bit of `rd_req_o` stays high until its own bit of `rd_gnt_i` or `kill_i` is sampled high.
- R5: A grant bit sampled high on a pending request clears that request bit in the next cycle and leaves the other bit unchanged. Operand 0 (bit 0) is captured from `src_a_i`, and operand 1 (bit 1) from `src_b_i`, in that same grant cycle. Values on the source buses at any other cycle are not used.
- R6: A grant bit whose request bit is low has no effect on the request bits or on an operand already captured.
- R7: An issue while `busy_o` is high is ignored. The request bits are not raised again and the captured opcode is kept.
- R8: The cycle after the last pending request is granted, `wr_req_o` is high and `result_o` holds the result. `wr_req_o` stays high until `wr_gnt_i` is sampled high. In the next cycle `wr_req_o` and `busy_o` are low.
- R9: `kill_i` sampled high while busy clears `rd_req_o`, `wr_req_o` and `busy_o` in the next cycle. Kill takes priority over grants and over a same-cycle issue.
- R10: The result is 16 bits wide and wraps modulo 2^16. Let A be operand 0 and B be operand 1. The `op_i` codes are 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 A^B, 5 A shifted left by B[3:0], 6 A shifted right (logical) by B[3:0], and 7 B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Issue strobe |
| op_i | input | 3 | Operation code, captured at issue |
| kill_i | input | 1 | Cancel the current operation |
| rd_req_o | output | 2 | Per-operand read request |
| rd_gnt_i | input | 2 | Per-operand read grant |
| src_a_i | input | 16 | Operand 0 value, sampled on its grant |
| src_b_i | input | 16 | Operand 1 value, sampled on its grant |
| wr_req_o | output | 1 | Result write request |
| wr_gnt_i | input | 1 | Result write grant |
| result_o | output | 16 | ALU result, valid while `wr_req_o` is high |
| busy_o | output | 1 | High from accepted issue until write grant or kill |

## Verification
The hardest situation to reach is a partially granted read phase, where one request is already cleared and the other is still pending. Only in that window can a stray repeat grant, a second issue or a kill act on mixed request state.

The stimulus reaches this window by granting the operands on separate cycles, in both orders. Inside the gap it:
- changes the idle source bus,
- grants the already-served bit again,
- pulses issue with a different opcode,
- in one run, kills the operation.

Every completed result goes through a queue of expected values, so any corrupted operand or opcode shows up as a mismatch.

// File: rtl/sbcu_pkg.sv
// Shared constants and types for the scoreboard computation unit front-end.
// Assumes exactly two source operands feeding a two-input ALU.
package sbcu_pkg;
    localparam int unsigned SBCU_DATA_W  = 16;
    localparam int unsigned SBCU_NUM_SRC = 2;
    localparam int unsigned SBCU_OP_W    = 3;

    typedef enum logic [SBCU_OP_W-1:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_AND   = 3'd2,
        ALU_OR    = 3'd3,
        ALU_XOR   = 3'd4,
        ALU_SHL   = 3'd5,
        ALU_SHR   = 3'd6,
        ALU_PASSB = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cu_state_e;
endpackage

// File: rtl/sbcu_src_slot.sv
// One operand slot: holds a read-request bit and the operand captured on grant.
// Assumes set_i is only pulsed when the unit is idle; kill wins over everything.
module sbcu_src_slot #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              kill_i,
    input  logic              gnt_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              req_o,
    output logic [DATA_W-1:0] data_o
);
    logic              req_q;
    logic [DATA_W-1:0] data_q;

    // Request bit: set on accepted issue, cleared by own grant or kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (kill_i) begin
            req_q <= 1'b0;
        end else if (set_i) begin
            req_q <= 1'b1;
        end else if (req_q && gnt_i) begin
            req_q <= 1'b0;
        end
    end

    // Operand capture: only a grant on a pending request loads the value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (!kill_i && req_q && gnt_i) begin
            data_q <= data_i;
        end
    end

    assign req_o  = req_q;
    assign data_o = data_q;
endmodule

// File: rtl/sbcu_alu.sv
// Combinational two-operand ALU; results wrap to DATA_W bits.
// Assumes shift amounts use only the low log2(DATA_W) bits of operand B.
module sbcu_alu
    import sbcu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int unsigned SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] shamt;
    assign shamt = b_i[SH_W-1:0];

    // Operation select.
    always_comb begin
        case (op_i)
            ALU_ADD:   res_o = a_i + b_i;
            ALU_SUB:   res_o = a_i - b_i;
            ALU_AND:   res_o = a_i & b_i;
            ALU_OR:    res_o = a_i | b_i;
            ALU_XOR:   res_o = a_i ^ b_i;
            ALU_SHL:   res_o = a_i << shamt;
            ALU_SHR:   res_o = a_i >> shamt;
            default:   res_o = b_i;
        endcase
    end
endmodule

// File: rtl/sbcu_ctrl.sv
// Sequencer for issue, operand read and result write phases.
// Assumes request bits come from the operand slots; kill returns to idle.
module sbcu_ctrl
    import sbcu_pkg::*;
#(
    parameter int unsigned NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  alu_op_e            op_i,
    input  logic               kill_i,
    input  logic [NUM_SRC-1:0] rd_req_i,
    input  logic [NUM_SRC-1:0] rd_gnt_i,
    input  logic               wr_gnt_i,
    output logic               accept_o,
    output alu_op_e            op_o,
    output logic               wr_req_o,
    output logic               busy_o
);
    cu_state_e state_q;
    alu_op_e   op_q;
    logic      reads_done;

    // All remaining requests are granted this cycle.
    assign reads_done = ((rd_req_i & ~rd_gnt_i) == '0);
    assign accept_o   = (state_q == ST_IDLE) && issue_i && !kill_i;

    // Phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (kill_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (issue_i)    state_q <= ST_READ;
                ST_READ:  if (reads_done) state_q <= ST_WRITE;
                ST_WRITE: if (wr_gnt_i)   state_q <= ST_IDLE;
                default:                  state_q <= ST_IDLE;
            endcase
        end
    end

    // Opcode capture on accepted issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= ALU_ADD;
        end else if (accept_o) begin
            op_q <= op_i;
        end
    end

    assign op_o     = op_q;
    assign wr_req_o = (state_q == ST_WRITE);
    assign busy_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/sb_cu_front.sv
// Scoreboard computation unit front-end: issue, per-operand read handshake,
// internal ALU, result write handshake, kill. Synchronous active-low reset.
module sb_cu_front
    import sbcu_pkg::*;
#(
    parameter int unsigned DATA_W = SBCU_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_i,
    input  logic [SBCU_OP_W-1:0] op_i,
    input  logic                 kill_i,
    output logic [1:0]           rd_req_o,
    input  logic [1:0]           rd_gnt_i,
    input  logic [DATA_W-1:0]    src_a_i,
    input  logic [DATA_W-1:0]    src_b_i,
    output logic                 wr_req_o,
    input  logic                 wr_gnt_i,
    output logic [DATA_W-1:0]    result_o,
    output logic                 busy_o
);
    localparam int unsigned NUM_SRC = SBCU_NUM_SRC;

    logic [DATA_W-1:0]  src_in  [NUM_SRC];
    logic [DATA_W-1:0]  opnd_q  [NUM_SRC];
    logic [NUM_SRC-1:0] req_vec;
    logic               accept;
    alu_op_e            op_cur;

    assign src_in[0] = src_a_i;
    assign src_in[1] = src_b_i;

    sbcu_ctrl #(.NUM_SRC(NUM_SRC)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue_i),
        .op_i     (alu_op_e'(op_i)),
        .kill_i   (kill_i),
        .rd_req_i (req_vec),
        .rd_gnt_i (rd_gnt_i),
        .wr_gnt_i (wr_gnt_i),
        .accept_o (accept),
        .op_o     (op_cur),
        .wr_req_o (wr_req_o),
        .busy_o   (busy_o)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        sbcu_src_slot #(.DATA_W(DATA_W)) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (accept),
            .kill_i (kill_i),
            .gnt_i  (rd_gnt_i[g]),
            .data_i (src_in[g]),
            .req_o  (req_vec[g]),
            .data_o (opnd_q[g])
        );
    end

    sbcu_alu #(.DATA_W(DATA_W)) alu_i (
        .op_i  (op_cur),
        .a_i   (opnd_q[0]),
        .b_i   (opnd_q[1]),
        .res_o (result_o)
    );

    assign rd_req_o = req_vec;
endmodule

// File: rtl/sb_cu_front_chk.sv
// Protocol checker for sb_cu_front, attached by bind.
// Assumes synchronous active-low reset; all properties disabled during reset.
module sb_cu_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       issue_i,
    input logic       kill_i,
    input logic [1:0] rd_req_o,
    input logic [1:0] rd_gnt_i,
    input logic       wr_req_o,
    input logic       wr_gnt_i,
    input logic       busy_o
);
    logic seen_issue;

    // Remember whether any issue has been observed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       seen_issue <= 1'b0;
        else if (issue_i) seen_issue <= 1'b1;
    end

    p_req_needs_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o != 2'b00) |-> seen_issue);

    p_req_rise_from_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o == 2'b00) |=> (rd_req_o == 2'b00) ||
                                 (rd_req_o == 2'b11 && $past(issue_i) && busy_o));

    p_req_implies_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o != 2'b00) |-> busy_o && !wr_req_o);

    for (genvar i = 0; i < 2; i++) begin : g_bit
        p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req_o[i] && !rd_gnt_i[i] && !kill_i) |=> rd_req_o[i]);
        p_gnt_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req_o[i] && rd_gnt_i[i]) |=> !rd_req_o[i]);
    end

    p_kill_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_i && busy_o) |=> (rd_req_o == 2'b00) && !wr_req_o && !busy_o);

    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_gnt_i && !kill_i) |=> wr_req_o);

    p_wr_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_gnt_i) |=> !wr_req_o && !busy_o);
endmodule

bind sb_cu_front sb_cu_front_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue_i),
    .kill_i   (kill_i),
    .rd_req_o (rd_req_o),
    .rd_gnt_i (rd_gnt_i),
    .wr_req_o (wr_req_o),
    .wr_gnt_i (wr_gnt_i),
    .busy_o   (busy_o)
);

// File: tb/sb_cu_front_tb_top.sv
// Scoreboard bench: driver pushes expected results, monitor pops on write request.
module sb_cu_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic        kill_i = 1'b0;
    logic [1:0]  rd_req_o;
    logic [1:0]  rd_gnt_i = 2'b00;
    logic [15:0] src_a_i = 16'h0;
    logic [15:0] src_b_i = 16'h0;
    logic        wr_req_o;
    logic        wr_gnt_i = 1'b0;
    logic [15:0] result_o;
    logic        busy_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q [$];
    logic        wr_seen = 1'b0;

    always #2ns clk = ~clk;

    sb_cu_front dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .kill_i(kill_i),
        .rd_req_o(rd_req_o), .rd_gnt_i(rd_gnt_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .wr_req_o(wr_req_o), .wr_gnt_i(wr_gnt_i), .result_o(result_o), .busy_o(busy_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a << b[3:0];
            3'd6: return a >> b[3:0];
            default: return b;
        endcase
    endfunction

    // Monitor: compare result against the queue once per write request.
    always @(negedge clk) begin
        if (wr_req_o && !wr_seen) begin
            wr_seen <= 1'b1;
            if (exp_q.size() == 0) begin
                chk("R8 unexpected write request", 32'd1, 32'd0);
            end else begin
                chk("R10 result", {16'h0, result_o}, {16'h0, exp_q.pop_front()});
            end
        end else if (!wr_req_o) begin
            wr_seen <= 1'b0;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic issue_op(input logic [2:0] op);
        issue_i = 1'b1; op_i = op;
        step();
        issue_i = 1'b0; op_i = ~op;
        chk("R2 both requests raised", {30'h0, rd_req_o}, 32'h3);
        chk("R2 busy after issue", {31'h0, busy_o}, 32'h1);
    endtask

    task automatic finish_write(input int wait_cycles);
        for (int k = 0; k < wait_cycles; k++) begin
            step();
            chk("R8 write request held", {31'h0, wr_req_o}, 32'h1);
        end
        wr_gnt_i = 1'b1;
        step();
        wr_gnt_i = 1'b0;
        chk("R8 write request dropped", {31'h0, wr_req_o}, 32'h0);
        chk("R8 busy dropped", {31'h0, busy_o}, 32'h0);
    endtask

    // Driver: mode 0 both grants together; mode 1 A then B; mode 2 B then A.
    task automatic do_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b, input int mode);
        exp_q.push_back(model(op, a, b));
        issue_op(op);
        if (mode == 0) begin
            src_a_i = a; src_b_i = b; rd_gnt_i = 2'b11;
            step();
            rd_gnt_i = 2'b00; src_a_i = ~a; src_b_i = ~b;
        end else if (mode == 1) begin
            src_a_i = a; src_b_i = ~b; rd_gnt_i = 2'b01;
            step();
            rd_gnt_i = 2'b00;
            chk("R5 only granted bit cleared", {30'h0, rd_req_o}, 32'h2);
            src_a_i = a ^ 16'h5a5a; rd_gnt_i = 2'b01;
            issue_i = 1'b1; op_i = op ^ 3'd3;
            step();
            rd_gnt_i = 2'b00; issue_i = 1'b0;
            chk("R6 R7 stray grant and issue ignored", {30'h0, rd_req_o}, 32'h2);
            src_b_i = b; rd_gnt_i = 2'b10;
            step();
            rd_gnt_i = 2'b00; src_b_i = ~b;
        end else begin
            src_b_i = b; src_a_i = ~a; rd_gnt_i = 2'b10;
            step();
            rd_gnt_i = 2'b00;
            chk("R5 bit1 cleared bit0 kept", {30'h0, rd_req_o}, 32'h1);
            step();
            chk("R4 request held without grant", {30'h0, rd_req_o}, 32'h1);
            src_a_i = a; src_b_i = 16'hdead; rd_gnt_i = 2'b01;
            step();
            rd_gnt_i = 2'b00; src_a_i = ~a;
        end
        chk("R8 requests clear after last grant", {30'h0, rd_req_o}, 32'h0);
        chk("R8 write request raised", {31'h0, wr_req_o}, 32'h1);
        finish_write(mode);
    endtask

    initial begin
        repeat (3) step();
        chk("R1 rd_req during reset", {30'h0, rd_req_o}, 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 rd_req after reset", {30'h0, rd_req_o}, 32'h0);
        chk("R1 wr_req after reset", {31'h0, wr_req_o}, 32'h0);
        chk("R1 busy after reset", {31'h0, busy_o}, 32'h0);

        rd_gnt_i = 2'b11; src_a_i = 16'h1111;
        step();
        rd_gnt_i = 2'b00;
        chk("R3 R6 grant without issue ignored", {30'h0, rd_req_o}, 32'h0);

        do_op(3'd0, 16'h0005, 16'h0005, 0);
        do_op(3'd0, 16'hffff, 16'h0002, 1);
        do_op(3'd1, 16'h0003, 16'h0007, 2);
        do_op(3'd2, 16'hf0f0, 16'h3c3c, 0);
        do_op(3'd3, 16'h1200, 16'h0034, 1);
        do_op(3'd4, 16'haaaa, 16'hffff, 2);
        do_op(3'd5, 16'h0001, 16'h001f, 0);
        do_op(3'd6, 16'h8000, 16'h0004, 1);
        do_op(3'd7, 16'h1234, 16'h4321, 2);

        kill_i = 1'b1; issue_i = 1'b1; op_i = 3'd0;
        step();
        kill_i = 1'b0; issue_i = 1'b0;
        chk("R9 kill blocks same-cycle issue", {31'h0, busy_o}, 32'h0);
        chk("R9 no requests after killed issue", {30'h0, rd_req_o}, 32'h0);

        issue_op(3'd0);
        src_a_i = 16'h0100; rd_gnt_i = 2'b01;
        step();
        rd_gnt_i = 2'b00;
        kill_i = 1'b1; rd_gnt_i = 2'b10;
        step();
        kill_i = 1'b0; rd_gnt_i = 2'b00;
        chk("R9 kill clears requests", {30'h0, rd_req_o}, 32'h0);
        chk("R9 kill clears busy", {31'h0, busy_o}, 32'h0);
        chk("R9 kill beats grant, no write", {31'h0, wr_req_o}, 32'h0);

        exp_q.push_back(16'h0000);
        issue_op(3'd7);
        rd_gnt_i = 2'b11; src_a_i = 16'h1; src_b_i = 16'h0;
        step();
        rd_gnt_i = 2'b00;
        chk("R8 write request before kill", {31'h0, wr_req_o}, 32'h1);
        kill_i = 1'b1;
        step();
        kill_i = 1'b0;
        chk("R9 kill drops write request", {31'h0, wr_req_o}, 32'h0);
        chk("R9 kill drops busy in write", {31'h0, busy_o}, 32'h0);

        do_op(3'd0, 16'h7fff, 16'h8001, 0);
        step();
        chk("R10 all expected results seen", exp_q.size(), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule